// File: doc/BRIEF.md
# Self-Testable Pulse-Reset Watchdog

This block supervises a processor. A timeout counter runs freely, and firmware keeps it from expiring by giving a strobe line a rising edge. If the counter reaches its limit without such an edge, the block does not hold the processor in reset. It issues a reset kick of a fixed number of cycles, so the processor restarts while the rest of the system keeps its state. In the same cycle it latches a fault. The fault turns off the motor enable and turns on the alarm.

A reset-cause flag records that the watchdog fired. At power-up, firmware can withhold strobes on purpose and let the timer expire. After the kick it reads the flag and tells a planned self-test from a real failure. The flag stays set until firmware clears it with an explicit request.

The fault latch is harder to release. A clear request is honoured only after the processor has shown it is alive again, that is, after a strobe edge seen outside the kick.

Top module: `pulse_watchdog`

## Requirements
- R1: While reset is asserted and right after it is released, cpu_rst_pulse_o is 0, motor_en_o is 1, alarm_o is 0 and wd_cause_o is 0.
- R2: Counting starts from zero when reset is released. If no strobe edge clears the count, cpu_rst_pulse_o goes to 1 at clock edge number TIMEOUT_CYCLES after release, where the first edge after release is edge 1. It is 0 at every earlier edge.
- R3: strobe_i passes through SYNC_STAGES synchronizing flops before edge detection. Take the first edge that samples strobe_i high as edge 1. A rising strobe restarts the count from zero, so the next kick begins at edge TIMEOUT_CYCLES+SYNC_STAGES+1.
- R4: A strobe held high clears the count only once. The kick still arrives at the time given in R3.
- R5: A kick lasts exactly KICK_CYCLES cycles. A strobe edge that falls inside a kick neither shortens nor extends it.
- R6: After a kick ends, the count restarts from zero. Without a strobe, the next kick starts exactly TIMEOUT_CYCLES cycles after the previous one deasserts.
- R7: On a timeout, motor_en_o goes to 0 and alarm_o goes to 1 in the same cycle as the kick starts. Both stay that way through the kick and through later timeouts until R8 releases them.
- R8: fault_clr_i releases the fault only if a strobe edge has been seen outside a kick since the last timeout. Without such an edge the request has no effect. When honoured, motor_en_o returns to 1 and alarm_o to 0 on the next edge.
- R9: wd_cause_o becomes 1 in the same cycle as the kick starts. It holds until a cycle with cause_clr_i high, after which it reads 0.
- R10: If cause_clr_i is high in the cycle a timeout occurs, the timeout wins and wd_cause_o reads 1.
- R11: If a strobe edge reaches the counter in the cycle that would otherwise expire, the strobe wins: no kick starts, and the count restarts as in R3. One cycle later is too late, and the kick starts on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Keep-alive strobe from the processor; the rising edge counts |
| fault_clr_i | input | 1 | Request to release the latched fault |
| cause_clr_i | input | 1 | Request to clear the reset-cause flag |
| cpu_rst_pulse_o | output | 1 | Reset kick to the processor, KICK_CYCLES long |
| motor_en_o | output | 1 | Motor driver enable, 0 while the fault is latched |
| alarm_o | output | 1 | Audible alarm enable, 1 while the fault is latched |
| wd_cause_o | output | 1 | Set when the last reset came from a timeout |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a strobe edge and the terminal count. The bench raises strobe_i so that, after the synchronizer, its edge reaches the counter exactly in the expiry cycle. It expects no kick at that edge and a full new window afterwards. It then repeats the test one cycle later and expects the kick on time.

The second pair is a cause-clear request and the timeout that sets the cause flag. The bench holds cause_clr_i high across the expiry edge and expects the flag to read set.

// File: rtl/wd_pkg.sv
package wd_pkg;

   typedef enum logic {
      WD_COUNT = 1'b0,
      WD_KICK  = 1'b1
   } wd_phase_e;

endpackage

// File: rtl/wd_strobe_edge.sv
module wd_strobe_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strobe_i,
   output logic rise_o
);

   logic level;
   logic level_prev_q;

   if (SYNC_STAGES > 8) begin : g_bad_sync
      $error("wd_strobe_edge: SYNC_STAGES must be 8 or less");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign level = strobe_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= strobe_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign level = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) level_prev_q <= 1'b0;
      else         level_prev_q <= level;
   end

   assign rise_o = level & ~level_prev_q;

   // a level held high yields one edge only
   assert_single_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/wd_timer.sv
module wd_timer
   import wd_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 200_000_000,
   parameter int unsigned KICK_CYCLES    = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   output logic expire_o,
   output logic kick_o,
   output logic counting_o
);

   localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
   localparam int KW = (KICK_CYCLES > 1) ? $clog2(KICK_CYCLES) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_CYCLES - 1);

   if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
      $error("wd_timer: TIMEOUT_CYCLES must be at least 2");
   end
   if (KICK_CYCLES < 1) begin : g_bad_kick
      $error("wd_timer: KICK_CYCLES must be at least 1");
   end

   wd_phase_e      phase_q;
   logic [CW-1:0]  cnt_q;
   logic           kick_last;

   // kick length: a counter only when the kick spans several cycles
   if (KICK_CYCLES == 1) begin : g_kick_single
      assign kick_last = 1'b1;
   end else begin : g_kick_multi
      localparam logic [KW-1:0] LAST_KICK = KW'(KICK_CYCLES - 1);
      logic [KW-1:0] kick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                 kick_q <= '0;
         else if (phase_q == WD_KICK && !kick_last)   kick_q <= kick_q + 1'b1;
         else                                         kick_q <= '0;
      end
      assign kick_last = (kick_q == LAST_KICK);
   end

   assign expire_o   = (phase_q == WD_COUNT) && (cnt_q == LAST_CNT) && !clear_i;
   assign kick_o     = (phase_q == WD_KICK);
   assign counting_o = (phase_q == WD_COUNT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= WD_COUNT;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            WD_COUNT: begin
               if (clear_i) begin
                  cnt_q <= '0;
               end else if (cnt_q == LAST_CNT) begin
                  phase_q <= WD_KICK;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            WD_KICK: begin
               cnt_q <= '0;
               if (kick_last) phase_q <= WD_COUNT;
            end
            default: phase_q <= WD_COUNT;
         endcase
      end
   end

   // checker: independent measure of the kick length
   logic [KW:0] chk_len_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chk_len_q <= '0;
      else if (kick_o) chk_len_q <= chk_len_q + 1'b1;
      else             chk_len_q <= '0;
   end

   assert_kick_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(kick_o) |-> (chk_len_q == (KW+1)'(KICK_CYCLES)));

   assert_kick_not_overlong_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kick_o |-> (chk_len_q < (KW+1)'(KICK_CYCLES)));

   assert_kick_after_full_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(kick_o) |-> ($past(cnt_q) == LAST_CNT));

   assert_count_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(kick_o) |-> (cnt_q == '0));

   assert_strobe_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_i && counting_o) |=> (counting_o && cnt_q == '0));

endmodule

// File: rtl/wd_fault_latch.sv
module wd_fault_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic expire_i,
   input  logic strobe_rise_i,
   input  logic counting_i,
   input  logic fault_clr_i,
   input  logic cause_clr_i,
   output logic fault_o,
   output logic cause_o
);

   logic fault_q;
   logic armed_q;
   logic cause_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fault_q <= 1'b0;
         armed_q <= 1'b0;
      end else if (expire_i) begin
         fault_q <= 1'b1;
         armed_q <= 1'b0;
      end else if (fault_q && armed_q && fault_clr_i) begin
         fault_q <= 1'b0;
         armed_q <= 1'b0;
      end else if (fault_q && strobe_rise_i && counting_i) begin
         armed_q <= 1'b1;
      end
   end

   // timeout takes priority over a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cause_q <= 1'b0;
      else if (expire_i)    cause_q <= 1'b1;
      else if (cause_clr_i) cause_q <= 1'b0;
   end

   assign fault_o = fault_q;
   assign cause_o = cause_q;

   assert_fault_on_expiry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i |=> (fault_q && !armed_q));

   assert_fault_release_guarded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(fault_q) |-> $past(fault_clr_i && armed_q));

   assert_cause_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i |=> cause_q);

   assert_cause_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cause_q) |-> $past(cause_clr_i));

endmodule

// File: rtl/pulse_watchdog.sv
module pulse_watchdog #(
   parameter int unsigned TIMEOUT_CYCLES = 200_000_000,
   parameter int unsigned KICK_CYCLES    = 16,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strobe_i,
   input  logic fault_clr_i,
   input  logic cause_clr_i,
   output logic cpu_rst_pulse_o,
   output logic motor_en_o,
   output logic alarm_o,
   output logic wd_cause_o
);

   logic strobe_rise;
   logic expire;
   logic kick;
   logic counting;
   logic fault;

   wd_strobe_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_i),
      .rise_o   (strobe_rise)
   );

   wd_timer #(
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
      .KICK_CYCLES    (KICK_CYCLES)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (strobe_rise),
      .expire_o   (expire),
      .kick_o     (kick),
      .counting_o (counting)
   );

   wd_fault_latch u_latch (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .expire_i      (expire),
      .strobe_rise_i (strobe_rise),
      .counting_i    (counting),
      .fault_clr_i   (fault_clr_i),
      .cause_clr_i   (cause_clr_i),
      .fault_o       (fault),
      .cause_o       (wd_cause_o)
   );

   assign cpu_rst_pulse_o = kick;
   assign motor_en_o      = ~fault;
   assign alarm_o         = fault;

   assert_kick_masks_motor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_rst_pulse_o |-> (!motor_en_o && alarm_o && wd_cause_o));

endmodule

// File: tb/pulse_watchdog_test.sv
`timescale 1ns/1ps
module pulse_watchdog_test;

   localparam int LIMIT = 40;
   localparam int KICK  = 6;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 1'b0;
   logic fclr = 1'b0;
   logic cclr = 1'b0;
   logic pulse, motor, alarm, cause;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pulse_watchdog #(
      .TIMEOUT_CYCLES (LIMIT),
      .KICK_CYCLES    (KICK),
      .SYNC_STAGES    (SYNC)
   ) uut (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .strobe_i        (strobe),
      .fault_clr_i     (fclr),
      .cause_clr_i     (cclr),
      .cpu_rst_pulse_o (pulse),
      .motor_en_o      (motor),
      .alarm_o         (alarm),
      .wd_cause_o      (cause)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n  = 1'b0;
      strobe = 1'b0;
      fclr   = 1'b0;
      cclr   = 1'b0;
      step(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      step(2);
      chk("R1", "pulse in reset", pulse, 1'b0);
      chk("R1", "motor in reset", motor, 1'b1);
      do_reset();
      chk("R1", "pulse", pulse, 1'b0);
      chk("R1", "motor", motor, 1'b1);
      chk("R1", "alarm", alarm, 1'b0);
      chk("R1", "cause", cause, 1'b0);
   endtask

   task automatic t_timeout_and_kick();
      do_reset();
      step(LIMIT - 1);
      chk("R2", "pulse before limit", pulse, 1'b0);
      step(1);
      chk("R2", "pulse at limit", pulse, 1'b1);
      chk("R7", "motor off", motor, 1'b0);
      chk("R7", "alarm on", alarm, 1'b1);
      chk("R9", "cause set", cause, 1'b1);
      step(KICK - 1);
      chk("R5", "pulse last cycle", pulse, 1'b1);
      step(1);
      chk("R5", "pulse ended", pulse, 1'b0);
      chk("R7", "motor still off", motor, 1'b0);
      step(LIMIT - 1);
      chk("R6", "no early second kick", pulse, 1'b0);
      step(1);
      chk("R6", "second kick", pulse, 1'b1);
      // strobe edge inside the kick
      strobe = 1'b1;
      step(KICK - 1);
      chk("R5", "kick not cut by strobe", pulse, 1'b1);
      step(1);
      chk("R5", "kick not stretched by strobe", pulse, 1'b0);
      fclr = 1'b1;
      step(1);
      fclr = 1'b0;
      chk("R8", "clear without strobe ignored", motor, 1'b0);
      chk("R8", "alarm kept", alarm, 1'b1);
      strobe = 1'b0;
      step(3);
      strobe = 1'b1;
      step(3);
      strobe = 1'b0;
      step(1);
      fclr = 1'b1;
      step(1);
      fclr = 1'b0;
      chk("R8", "motor released", motor, 1'b1);
      chk("R8", "alarm released", alarm, 1'b0);
      chk("R9", "cause held", cause, 1'b1);
      cclr = 1'b1;
      step(1);
      cclr = 1'b0;
      chk("R9", "cause cleared", cause, 1'b0);
   endtask

   task automatic t_strobe_clear();
      do_reset();
      step(10);
      strobe = 1'b1;
      step(2);
      strobe = 1'b0;
      step(LIMIT);
      chk("R3", "no kick before new window", pulse, 1'b0);
      step(1);
      chk("R3", "kick after new window", pulse, 1'b1);
   endtask

   task automatic t_held_strobe();
      do_reset();
      step(5);
      strobe = 1'b1;
      step(LIMIT + SYNC);
      chk("R4", "held strobe: no kick yet", pulse, 1'b0);
      step(1);
      chk("R4", "held strobe clears once", pulse, 1'b1);
      strobe = 1'b0;
   endtask

   task automatic t_cause_race();
      do_reset();
      step(LIMIT - 1);
      cclr = 1'b1;
      step(1);
      cclr = 1'b0;
      chk("R10", "kick", pulse, 1'b1);
      chk("R10", "cause set wins", cause, 1'b1);
   endtask

   task automatic t_strobe_race();
      do_reset();
      step(LIMIT - 1 - SYNC);
      strobe = 1'b1;
      step(SYNC + 1);
      strobe = 1'b0;
      chk("R11", "strobe at expiry wins", pulse, 1'b0);
      chk("R11", "no fault", motor, 1'b1);
      step(LIMIT - 1);
      chk("R11", "window restarted", pulse, 1'b0);
      step(1);
      chk("R11", "kick after restarted window", pulse, 1'b1);
      do_reset();
      step(LIMIT - SYNC);
      strobe = 1'b1;
      step(SYNC - 1);
      chk("R11", "late strobe, before expiry", pulse, 1'b0);
      step(1);
      strobe = 1'b0;
      chk("R11", "late strobe too late", pulse, 1'b1);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      t_reset_state();
      t_timeout_and_kick();
      t_strobe_clear();
      t_held_strobe();
      t_cause_race();
      t_strobe_race();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

endmodule